// File: doc/BRIEF.md
# Triggered DMA Channel

This block is a single direct-memory-access channel. Software programs four registers over a simple write port: a 16-bit control word, a source address, a destination address and a unit count. When a control write turns the enable bit from 0 to 1, the channel copies the three programmed values into working copies. It then waits for its selected start condition: an immediate start, a vertical-blank strobe or a horizontal-blank strobe.

Once started, the channel moves one block of halfwords or words. For each unit it runs a read cycle on its memory master port, then a write cycle. Each address steps after each unit according to its own control field. When the block ends, the channel either clears its enable bit (single shot) or reloads and re-arms (repeat). It can raise a one-cycle interrupt pulse when a block finishes.

The sequencer has five states:
- **IDLE**: the channel does nothing.
- **ARMED**: the channel waits for its start condition.
- **READ**: a read strobe is held until the memory signals ready.
- **WRITE**: a write strobe is held until the memory signals ready.
- **FINISH**: a single cycle for completion.

It has these transitions:
- *arm*: any state goes to ARMED when enable rises.
- *disarm*: ARMED goes to IDLE when enable is low.
- *start*: ARMED goes to READ when the start condition is met.
- *fetched*: READ goes to WRITE on ready.
- *next-unit*: WRITE goes to READ on ready while units remain.
- *last-unit*: WRITE goes to FINISH on ready for the final unit.
- *rearm*: FINISH goes to ARMED when repeat is set.
- *retire*: FINISH goes to IDLE when repeat is clear.

Top module: `dma_channel`

## Requirements
- R1: A write with `reg_sel` 0 stores `reg_wdata[15:0]` as the control word, 1 the source address, 2 the destination address, 3 the count (low `CNT_W` bits). `ctrl_rdata` always shows all 16 stored control bits, including bits 4:0 and the request bit 11.
- R2: Only a control write that takes enable (bit 15) from 0 to 1 loads the working source, destination and count. A programmed count of 0 loads 2^`CNT_W` units.
- R3: The start field (bits 13:12) is decoded as follows. Value 0 starts at once. Value 1 starts on a `vblank` strobe, and `hblank` has no effect. Value 2 starts on an `hblank` strobe, and `vblank` has no effect. Value 3 never starts. The request bit 11 has no effect.
- R4: Width bit 10 set moves 32-bit units with `mem_size`=1 and a unit step of 4. Width bit 10 clear moves 16-bit units with `mem_size`=0 and a unit step of 2.
- R5: The source field (bits 8:7) and the destination field (bits 6:5) each select a step. Value 0 adds one unit, 1 subtracts one unit, 2 keeps the address fixed, and 3 adds one unit.
- R6: Each unit is one read from the working source, followed by one write of the read data to the working destination. `mem_rd` and `mem_wr` are never high together, and a strobe and its address hold until `mem_ready`.
- R7: When a block ends with repeat (bit 9) clear, the control word becomes its old value AND 0x7FE0: enable drops, bits 4:0 read zero, and the other bits keep their values.
- R8: When a block ends with repeat set, enable stays set and the channel re-arms. The count reloads from the programmed count. The destination reloads only when its field is 3. The source continues from where it stopped.
- R9: When bit 14 is set, `irq` pulses high for exactly one cycle per finished block. When bit 14 is clear, `irq` stays low.
- R10: After reset, the control word is 0 and `mem_rd`, `mem_wr` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 source, 2 destination, 3 count) |
| reg_wdata | input | ADDR_W | Register write data |
| ctrl_rdata | output | 16 | Current control word |
| hblank | input | 1 | Horizontal-blank start strobe |
| vblank | input | 1 | Vertical-blank start strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address of the current access |
| mem_size | output | 1 | 0 for halfword, 1 for word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Completes the current read or write |
| irq | output | 1 | Block-complete interrupt pulse |

## Verification
The assertions check the following on every cycle:
- read and write strobes never overlap, and a stalled access holds its strobe and address;
- the interrupt is never longer than one cycle;
- an arming write leaves enable set;
- a single-shot completion clears enable and the low five bits;
- a channel armed with the special start value issues no read;
- the working count is never zero while moving data.

Only the bench scenarios can show the following:
- that the memory image after a block is correct for each width and step combination;
- that the blanking strobes are told apart;
- that a zero count means the maximum;
- that repeat reloads the destination only in reload mode while the source runs on.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        AC_INC   = 2'd0,
        AC_DEC   = 2'd1,
        AC_FIX   = 2'd2,
        AC_INCRL = 2'd3
    } addr_ctl_e;

    typedef enum logic [1:0] {
        ST_IMM  = 2'd0,
        ST_VBL  = 2'd1,
        ST_HBL  = 2'd2,
        ST_CUST = 2'd3
    } start_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_SRC  = 2'd1,
        SEL_DST  = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_READ,
        S_WRITE,
        S_FINISH
    } state_e;

    // Packed MSB first: bit 15 down to bit 0
    typedef struct packed {
        logic      en;
        logic      irq_en;
        start_e    timing;
        logic      drq;
        logic      wide;
        logic      rpt;
        addr_ctl_e src_ctl;
        addr_ctl_e dst_ctl;
        logic [4:0] low;
    } ctrl_t;

    localparam logic [15:0] DONE_KEEP_MASK = 16'h7FE0;

    function automatic logic signed [3:0] addr_delta(addr_ctl_e mode, logic wide);
        logic signed [3:0] unit;
        logic signed [3:0] r;
        unit = wide ? 4'sd4 : 4'sd2;
        unique case (mode)
            AC_INC, AC_INCRL: r = unit;
            AC_DEC:           r = -unit;
            default:          r = 4'sd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              done_clr,
    output ctrl_t             ctrl_q,
    output logic [ADDR_W-1:0] prog_src,
    output logic [ADDR_W-1:0] prog_dst,
    output logic [CNT_W-1:0]  prog_cnt,
    output logic              arm
);

    logic wr_ctrl;
    logic en_effective;

    assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
    // A completion in the same cycle counts as enable already low
    assign en_effective = ctrl_q.en && !done_clr;
    assign arm = wr_ctrl && reg_wdata[15] && !en_effective;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            prog_src <= '0;
            prog_dst <= '0;
            prog_cnt <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(reg_wdata[15:0]);
            end else if (done_clr) begin
                ctrl_q <= ctrl_t'(ctrl_q & DONE_KEEP_MASK);
            end
            if (reg_we && reg_sel == SEL_SRC) prog_src <= reg_wdata;
            if (reg_we && reg_sel == SEL_DST) prog_dst <= reg_wdata;
            if (reg_we && reg_sel == SEL_CNT) prog_cnt <= reg_wdata[CNT_W-1:0];
        end
    end

    a_r2_arm_sets_enable: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> ctrl_q.en);

    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !wr_ctrl) |=> (!ctrl_q.en && ctrl_q.low == 5'd0));

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic [ADDR_W-1:0] prog_src,
    input  logic [ADDR_W-1:0] prog_dst,
    input  logic [CNT_W-1:0]  prog_cnt,
    input  logic              arm,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_size,
    output logic [31:0]       mem_wdata,
    output logic              irq,
    output logic              done_clr
);

    localparam int CW = CNT_W + 1;
    localparam logic [CW-1:0] MAX_UNITS = {1'b1, {CNT_W{1'b0}}};

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] work_src, work_dst;
    logic [CW-1:0]     work_cnt;
    logic [31:0]       data_q;
    logic              go;
    logic [CW-1:0]     cnt_load;
    logic signed [3:0] d_src, d_dst;
    logic [ADDR_W-1:0] step_src, step_dst;

    assign cnt_load = (prog_cnt == '0) ? MAX_UNITS : {1'b0, prog_cnt};
    assign d_src    = addr_delta(ctrl.src_ctl, ctrl.wide);
    assign d_dst    = addr_delta(ctrl.dst_ctl, ctrl.wide);
    assign step_src = {{(ADDR_W-4){d_src[3]}}, d_src};
    assign step_dst = {{(ADDR_W-4){d_dst[3]}}, d_dst};

    always_comb begin
        unique case (ctrl.timing)
            ST_IMM:  go = 1'b1;
            ST_VBL:  go = vblank;
            ST_HBL:  go = hblank;
            default: go = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = S_IDLE;
            S_ARMED:  if (!ctrl.en) state_d = S_IDLE;
                      else if (go) state_d = S_READ;
            S_READ:   if (mem_ready) state_d = S_WRITE;
            S_WRITE:  if (mem_ready) state_d = (work_cnt == CW'(1)) ? S_FINISH : S_READ;
            S_FINISH: state_d = ctrl.rpt ? S_ARMED : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
        if (arm) state_d = S_ARMED;
    end

    // Working copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_src <= '0;
            work_dst <= '0;
            work_cnt <= '0;
            data_q   <= '0;
        end else if (arm) begin
            work_src <= prog_src;
            work_dst <= prog_dst;
            work_cnt <= cnt_load;
        end else begin
            unique case (state_q)
                S_READ: if (mem_ready) data_q <= mem_rdata;
                S_WRITE: if (mem_ready) begin
                    work_src <= work_src + step_src;
                    work_dst <= work_dst + step_dst;
                    work_cnt <= work_cnt - CW'(1);
                end
                S_FINISH: if (ctrl.rpt) begin
                    work_cnt <= cnt_load;
                    if (ctrl.dst_ctl == AC_INCRL) work_dst <= prog_dst;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_rd    = (state_q == S_READ);
        mem_wr    = (state_q == S_WRITE);
        mem_addr  = (state_q == S_READ) ? work_src : work_dst;
        mem_size  = ctrl.wide;
        mem_wdata = data_q;
        irq       = (state_q == S_FINISH) && ctrl.irq_en;
        done_clr  = (state_q == S_FINISH) && !ctrl.rpt;
    end

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r6_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready && !arm) |=> (mem_rd && $stable(mem_addr)));

    a_r6_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready && !arm) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r3_custom_never_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && ctrl.timing == ST_CUST && !arm) |=> !mem_rd);

    a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (work_cnt != '0));

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [15:0]       ctrl_rdata,
    input  logic              hblank,
    input  logic              vblank,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic              irq
);

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] prog_src, prog_dst;
    logic [CNT_W-1:0]  prog_cnt;
    logic              arm, done_clr;

    dma_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .done_clr (done_clr),
        .ctrl_q   (ctrl_q),
        .prog_src (prog_src),
        .prog_dst (prog_dst),
        .prog_cnt (prog_cnt),
        .arm      (arm)
    );

    dma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl_q),
        .prog_src (prog_src),
        .prog_dst (prog_dst),
        .prog_cnt (prog_cnt),
        .arm      (arm),
        .hblank   (hblank),
        .vblank   (vblank),
        .mem_ready(mem_ready),
        .mem_rdata(mem_rdata),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_addr (mem_addr),
        .mem_size (mem_size),
        .mem_wdata(mem_wdata),
        .irq      (irq),
        .done_clr (done_clr)
    );

    assign ctrl_rdata = ctrl_q;

endmodule

// File: tb/dma_channel_test.sv
module dma_channel_test;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_sel = '0;
    logic [ADDR_W-1:0] reg_wdata = '0;
    logic [15:0]       ctrl_rdata;
    logic              hblank = 1'b0, vblank = 1'b0;
    logic              mem_rd, mem_wr, mem_size;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata, mem_rdata;
    logic              mem_ready;
    logic              irq;

    always #2 clk = ~clk;

    dma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .hblank(hblank),
        .vblank(vblank), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .irq(irq)
    );

    // Memory model: 1 KiB, little-endian, random ready
    logic [7:0] tb_mem  [1024];
    logic [7:0] exp_mem [1024];
    logic       init_req = 1'b0;
    logic [7:0] lfsr;
    logic [9:0] ma;

    assign ma        = mem_addr[9:0];
    assign mem_ready = lfsr[0] | lfsr[2];
    assign mem_rdata = {tb_mem[ma+10'd3], tb_mem[ma+10'd2], tb_mem[ma+10'd1], tb_mem[ma]};

    function automatic logic [7:0] pat(int i);
        return 8'(i * 13 + 5);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) lfsr <= 8'hA5;
        else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (init_req) begin
            for (int i = 0; i < 1024; i++) tb_mem[i] <= pat(i);
        end else if (mem_wr && mem_ready) begin
            tb_mem[ma]        <= mem_wdata[7:0];
            tb_mem[ma+10'd1]  <= mem_wdata[15:8];
            if (mem_size) begin
                tb_mem[ma+10'd2] <= mem_wdata[23:16];
                tb_mem[ma+10'd3] <= mem_wdata[31:24];
            end
        end
    end

    int irq_cnt = 0;
    always @(posedge clk) if (rst_n && irq) irq_cnt++;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_h();
        @(negedge clk); hblank = 1'b1;
        @(negedge clk); hblank = 1'b0;
    endtask

    task automatic pulse_v();
        @(negedge clk); vblank = 1'b1;
        @(negedge clk); vblank = 1'b0;
    endtask

    task automatic init_mem();
        for (int i = 0; i < 1024; i++) exp_mem[i] = pat(i);
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int t = 0;
        while (ctrl_rdata[15] && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 2000, tag, 32'(t), 32'd2000);
    endtask

    task automatic cmp_mem(string tag);
        int bad = 0;
        for (int i = 0; i < 1024; i++) if (tb_mem[i] !== exp_mem[i]) bad++;
        chk(bad == 0, tag, 32'(bad), 32'd0);
    endtask

    // Arithmetic model of one block
    task automatic model_block(inout int s, inout int d, input int sc, input int dc,
                               input int wide, input int n);
        int sz = wide ? 4 : 2;
        int ss = (sc == 1) ? -sz : (sc == 2) ? 0 : sz;
        int ds = (dc == 1) ? -sz : (dc == 2) ? 0 : sz;
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < sz; b++) exp_mem[(d + b) & 1023] = exp_mem[(s + b) & 1023];
            s += ss;
            d += ds;
        end
    endtask

    initial begin
        int s, d;
        int i0;
        logic [15:0] cv;

        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(ctrl_rdata == 16'h0, "R10 ctrl after reset", 32'(ctrl_rdata), 32'h0);
        chk(!mem_rd && !mem_wr && !irq, "R10 strobes after reset",
            {29'd0, mem_rd, mem_wr, irq}, 32'd0);

        // R1 full readback, no arm while enable low
        wr(0, 32'h381F);
        chk(ctrl_rdata == 16'h381F, "R1 control readback", 32'(ctrl_rdata), 32'h381F);
        wr(0, 32'h0);

        // Sweep: width x source mode x destination mode x count, immediate start
        for (int w = 0; w < 2; w++)
            for (int sc = 0; sc < 3; sc++)
                for (int dc = 0; dc < 3; dc++)
                    for (int n = 1; n <= 3; n++) begin
                        init_mem();
                        i0 = irq_cnt;
                        cv = 16'h8000 | ((n % 2) ? 16'h4000 : 16'h0) | 16'(w << 10)
                           | 16'(sc << 7) | 16'(dc << 5) | 16'h0015;
                        wr(1, 32'h100);
                        wr(2, 32'h300);
                        wr(3, 32'(n));
                        wr(0, 32'(cv));
                        wait_done("R2 immediate block completes");
                        idle(2);
                        s = 'h100; d = 'h300;
                        model_block(s, d, sc, dc, w, n);
                        cmp_mem("R4 R5 R6 memory after block");
                        chk(ctrl_rdata == (cv & 16'h7FE0), "R7 control after single shot",
                            32'(ctrl_rdata), 32'(cv & 16'h7FE0));
                        chk(irq_cnt - i0 == (n % 2), "R9 interrupt count",
                            32'(irq_cnt - i0), 32'(n % 2));
                    end

        // R2 count 0 means 2^CNT_W units
        init_mem();
        wr(1, 32'h100); wr(2, 32'h300); wr(3, 32'h0);
        wr(0, 32'h8000);
        wait_done("R2 zero count completes");
        idle(2);
        s = 'h100; d = 'h300;
        model_block(s, d, 0, 0, 0, 1 << CNT_W);
        cmp_mem("R2 zero count moves maximum");

        // R3 vblank start, hblank ignored
        init_mem();
        wr(1, 32'h100); wr(2, 32'h300); wr(3, 32'd2);
        wr(0, 32'h9000);
        idle(10);
        cmp_mem("R3 vblank mode waits");
        pulse_h();
        idle(10);
        cmp_mem("R3 vblank mode ignores hblank");
        chk(ctrl_rdata == 16'h9000, "R3 still enabled", 32'(ctrl_rdata), 32'h9000);
        pulse_v();
        wait_done("R3 vblank start completes");
        idle(2);
        s = 'h100; d = 'h300;
        model_block(s, d, 0, 0, 0, 2);
        cmp_mem("R3 vblank block");

        // R3 hblank start, vblank ignored
        init_mem();
        wr(0, 32'hA000);
        idle(10);
        pulse_v();
        idle(10);
        cmp_mem("R3 hblank mode ignores vblank");
        pulse_h();
        wait_done("R3 hblank start completes");
        idle(2);
        s = 'h100; d = 'h300;
        model_block(s, d, 0, 0, 0, 2);
        cmp_mem("R3 hblank block");

        // R3 special start value and request bit: no transfer
        init_mem();
        wr(0, 32'hB800);
        pulse_h(); pulse_v();
        idle(20);
        cmp_mem("R3 special start moves nothing");
        chk(ctrl_rdata == 16'hB800, "R3 special start stays enabled",
            32'(ctrl_rdata), 32'hB800);
        wr(0, 32'h0);

        // R8 repeat with destination reload
        init_mem();
        i0 = irq_cnt;
        wr(1, 32'h100); wr(2, 32'h300); wr(3, 32'd2);
        wr(0, 32'hE260);
        pulse_h();
        idle(120);
        s = 'h100; d = 'h300;
        model_block(s, d, 0, 3, 0, 2);
        cmp_mem("R8 first repeat block");
        chk(ctrl_rdata == 16'hE260, "R8 enable kept in repeat", 32'(ctrl_rdata), 32'hE260);
        chk(irq_cnt - i0 == 1, "R9 one pulse first block", 32'(irq_cnt - i0), 32'd1);
        pulse_h();
        idle(120);
        d = 'h300;
        model_block(s, d, 0, 3, 0, 2);
        cmp_mem("R8 destination reloaded, source continued");
        chk(irq_cnt - i0 == 2, "R9 one pulse second block", 32'(irq_cnt - i0), 32'd2);
        wr(0, 32'h0);

        // R8 repeat with incrementing destination (no reload), no interrupt
        init_mem();
        i0 = irq_cnt;
        wr(0, 32'hA200);
        pulse_h();
        idle(120);
        s = 'h100; d = 'h300;
        model_block(s, d, 0, 0, 0, 2);
        pulse_h();
        idle(120);
        model_block(s, d, 0, 0, 0, 2);
        cmp_mem("R8 destination continues without reload");
        chk(irq_cnt == i0, "R9 no pulse when disabled", 32'(irq_cnt - i0), 32'd0);
        wr(0, 32'h0);
        idle(2);
        chk(ctrl_rdata == 16'h0, "R1 control cleared by write", 32'(ctrl_rdata), 32'h0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule